// File: doc/BRIEF.md
# Converter Serial Result Transmitter

This block sends each 18-bit conversion result to a host over a serial link, most significant bit first. A host starts a conversion with `conv_go`. The analog converter is outside the block and is represented by a result strobe (`res_strobe`) that carries the result word (`res_word`) a fixed number of cycles later. While a conversion is in progress, the block reports it on `conv_busy`.

Two clock sources are supported. With the internal source, the block produces its own serial clock, at a rate the host can slow down, and a frame sync that marks the data window. With the external source, the host supplies the serial clock. That clock is honoured only while the chip select and the read strobe are both low. It may run continuously, or in bursts that rest high or low.

In the store-then-send read mode, a result is held back. It is sent while the following conversion runs. In the default mode, a result is sent as soon as it arrives.

Top module: `adc_serial_tx`

## Requirements
- R1: After the result strobe, the internal-clock transfer presents the bits in order from bit 17 down to bit 0, one bit per serial clock period. `ser_data` changes only when the serial clock goes from high to low. `ser_data` is 0 whenever no transfer is in progress.
- R2: `rate_sel` = d sets the internal serial clock period to 2^(d+1) system cycles, half of it low and half high. The encodings 0, 1, 2 and 3 give the system clock divided by 2, 4, 8 and 16.
- R3: `conv_busy` rises the cycle after an accepted `conv_go`. In the default read mode with the internal clock, it stays high until the 18th bit period ends. In every other mode it falls the cycle after the result strobe.
- R4: With the internal clock, `frame_sync` is active for the whole 18-bit window and inactive otherwise. The serial clock rests low outside the window.
- R5: `clk_pol_inv` = 1 inverts `ser_clk`, and `sync_pol_inv` = 1 inverts `frame_sync`. This applies both at rest and during a transfer. With both at 0, the clock rests low and the sync is active high.
- R6: With `read_during` = 1, a result is stored rather than sent. Its transfer starts at the next accepted `conv_go`, while that conversion runs.
- R7: With the external clock (`clk_src_ext` = 1), bits advance only while `chip_sel_n` and `read_n` are both low. At other times the external clock is ignored and `ser_data` is 0. `ser_clk` and `frame_sync` stay at their resting levels.
- R8: With the external clock, a bit advances on a falling edge of `ext_clk` XOR `clk_pol_inv`, but only if a rising edge has been seen since selection or since the last advance. This makes a burst clock that rests high or low behave the same.
- R9: If a new result arrives before the previous one is fully sent, it replaces the previous one and sending restarts from bit 17.
- R10: `conv_go` is ignored while `conv_busy` is high. `res_strobe` is ignored when no conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_go | input | 1 | Start a conversion (single-cycle pulse) |
| res_strobe | input | 1 | Converter result valid (single-cycle pulse) |
| res_word | input | 18 | Conversion result |
| clk_src_ext | input | 1 | 0: internal serial clock, 1: external serial clock |
| read_during | input | 1 | 1: send the previous result during the next conversion |
| rate_sel | input | 2 | Internal serial clock divide select |
| clk_pol_inv | input | 1 | Invert the serial clock polarity |
| sync_pol_inv | input | 1 | Invert the frame sync polarity |
| chip_sel_n | input | 1 | Chip select, active low |
| read_n | input | 1 | Read strobe, active low |
| ext_clk | input | 1 | External serial clock, synchronous to `clk` |
| conv_busy | output | 1 | Conversion (or held transfer) in progress |
| ser_clk | output | 1 | Generated serial clock |
| frame_sync | output | 1 | Frame sync for the data window |
| ser_data | output | 1 | Serial data out |

## Verification
All four outputs are due one system cycle after the edge that samples their cause. For example, `conv_busy` is due the cycle after `conv_go`, bit 17 the cycle after the result strobe, and the next bit the cycle after a qualifying external falling edge or the end of an internal clock period. Internal-clock bit k then holds for 2^(d+1) cycles. The bench updates a behavioural model on each rising edge from the same inputs the design samples. It drives inputs only on falling edges and compares every output a quarter period after each falling edge. As a result, every registered change has settled and no input is in motion when a comparison is made.

// File: rtl/adc_serial_pkg.sv
// Shared definitions for the serial result transmitter.
// Assumes: nothing beyond standard SystemVerilog.
package adc_serial_pkg;

    // Serial clock source selected by the clk_src_ext pin.
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

    // Result width used as the default of the top module.
    localparam int RESULT_W = 18;

    // Width of the internal clock divide select.
    localparam int RATE_SEL_W = 2;

endpackage

// File: rtl/tx_bit_clock.sv
// Internal serial clock generator.
// While run is high it toggles phase every 2^rate_sel system cycles, starting low.
// fall_tick marks the cycle whose edge ends a bit period (phase high to low).
// Assumes rate_sel is stable while run is high; restart realigns to the start of a bit.
module tx_bit_clock #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] rate_sel,
    output logic             phase,
    output logic             fall_tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   lim_full;
    logic             at_lim;

    // Last count of a half period, 2^rate_sel - 1.
    assign lim_full = ({{CNT_W{1'b0}}, 1'b1} << rate_sel) - {{CNT_W{1'b0}}, 1'b1};
    assign at_lim   = ({1'b0, cnt} == lim_full);
    assign fall_tick = run && !restart && at_lim && phase;

    // Half-period counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (at_lim) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        run && !restart && !at_lim |=> $stable(phase)); // R2

endmodule

// File: rtl/tx_ext_edge.sv
// External serial clock qualifier.
// Detects edges of ext_clk (after polarity inversion) in the system clock domain.
// A falling edge advances a bit only if a rising edge was seen while selected.
// Assumes ext_clk is synchronous to clk and each level lasts at least one cycle.
module tx_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel,
    input  logic restart,
    input  logic ext_clk,
    input  logic pol_inv,
    output logic adv
);
    logic lvl;
    logic lvl_q;
    logic armed;
    logic rise;
    logic fall;

    assign lvl  = ext_clk ^ pol_inv;
    assign rise = lvl && !lvl_q;
    assign fall = !lvl && lvl_q;
    assign adv  = en && sel && !restart && fall && armed;

    // Previous level of the external clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Arm on a rising edge while selected; disarm on a fall or on deselection.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !sel || restart) armed <= 1'b0;
        else if (rise)                        armed <= 1'b1;
        else if (fall)                        armed <= 1'b0;
    end

    AST_DESEL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !armed); // R7

    AST_ADV_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !armed); // R8

endmodule

// File: rtl/tx_word_shifter.sv
// Result holding and shifting.
// load_now starts sending data at once. store parks data until launch and aborts any transfer.
// Each adv presents the next bit; the adv on the last bit ends the transfer.
// Assumes store and launch never coincide (one needs a conversion, the other its absence).
module tx_word_shifter #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_now,
    input  logic              store,
    input  logic              launch,
    input  logic              adv,
    input  logic [WORD_W-1:0] data,
    output logic              active,
    output logic              msb,
    output logic              restart
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] hold;
    logic              pend;
    logic [CW-1:0]     bitn;

    assign restart = load_now || (launch && pend);
    assign msb     = word[WORD_W-1];

    // Transfer state: load, launch, advance; a store aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word   <= '0;
            active <= 1'b0;
            bitn   <= '0;
        end else begin
            if (load_now) begin
                word   <= data;
                active <= 1'b1;
                bitn   <= '0;
            end else if (launch && pend) begin
                word   <= hold;
                active <= 1'b1;
                bitn   <= '0;
            end else if (adv && active) begin
                if (bitn == LAST) begin
                    active <= 1'b0;
                end else begin
                    bitn <= bitn + 1'b1;
                    word <= {word[WORD_W-2:0], 1'b0};
                end
            end
            if (store) active <= 1'b0;
        end
    end

    // Parked result for the read-during-next-conversion mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            pend <= 1'b0;
        end else if (store) begin
            hold <= data;
            pend <= 1'b1;
        end else if (launch && pend) begin
            pend <= 1'b0;
        end
    end

    AST_RESTART_AT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> active && (bitn == '0)); // R9

    AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> bitn <= LAST); // R1

endmodule

// File: rtl/adc_serial_tx.sv
// Serial result transmitter top.
// Tracks the conversion, picks the serial clock source and forms the outputs.
// Assumes mode pins are static while a conversion or transfer is in progress.
// Assumes res_strobe arrives a fixed time after conv_go from an external converter model.
module adc_serial_tx
    import adc_serial_pkg::*;
#(
    parameter int WORD_W = RESULT_W,
    parameter int DIV_W  = RATE_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_go,
    input  logic              res_strobe,
    input  logic [WORD_W-1:0] res_word,
    input  logic              clk_src_ext,
    input  logic              read_during,
    input  logic [DIV_W-1:0]  rate_sel,
    input  logic              clk_pol_inv,
    input  logic              sync_pol_inv,
    input  logic              chip_sel_n,
    input  logic              read_n,
    input  logic              ext_clk,
    output logic              conv_busy,
    output logic              ser_clk,
    output logic              frame_sync,
    output logic              ser_data
);
    clk_src_e src;
    logic     internal;
    logic     sel;
    logic     conv;
    logic     start_ok;
    logic     done_ok;
    logic     active;
    logic     msb;
    logic     restart;
    logic     phase;
    logic     int_tick;
    logic     ext_tick;
    logic     adv;

    assign src      = clk_src_e'(clk_src_ext);
    assign internal = (src == SRC_INTERNAL);
    assign sel      = !chip_sel_n && !read_n;
    assign start_ok = conv_go && !conv_busy;
    assign done_ok  = res_strobe && conv;
    assign adv      = internal ? int_tick : ext_tick;

    // Busy covers the conversion, plus the transfer in the default internal-clock mode.
    assign conv_busy  = conv || (internal && !read_during && active);
    assign ser_clk    = ((internal && active) ? phase : 1'b0) ^ clk_pol_inv;
    assign frame_sync = (internal && active) ^ sync_pol_inv;
    assign ser_data   = (active && (internal || sel)) ? msb : 1'b0;

    // Conversion phase: from an accepted start to the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        conv <= 1'b0;
        else if (start_ok) conv <= 1'b1;
        else if (done_ok)  conv <= 1'b0;
    end

    tx_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_now (done_ok && !read_during),
        .store    (done_ok && read_during),
        .launch   (start_ok && read_during),
        .adv      (adv),
        .data     (res_word),
        .active   (active),
        .msb      (msb),
        .restart  (restart)
    );

    tx_bit_clock #(.DIV_W(DIV_W)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (internal && active),
        .restart   (restart),
        .rate_sel  (rate_sel),
        .phase     (phase),
        .fall_tick (int_tick)
    );

    tx_ext_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!internal && active),
        .sel     (sel),
        .restart (restart),
        .ext_clk (ext_clk),
        .pol_inv (clk_pol_inv),
        .adv     (ext_tick)
    );

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> conv_busy); // R3

    AST_CONV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        conv && !res_strobe |=> conv); // R10

    AST_ADV_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> active); // R1

endmodule

// File: tb/test_adc_serial_tx.sv
module test_adc_serial_tx;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_go = 1'b0, res_strobe = 1'b0;
    logic [17:0] res_word = '0;
    logic        clk_src_ext = 1'b0, read_during = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        clk_pol_inv = 1'b0, sync_pol_inv = 1'b0;
    logic        chip_sel_n = 1'b1, read_n = 1'b1, ext_clk = 1'b0;
    logic        conv_busy, ser_clk, frame_sync, ser_data;

    int    vectors = 0, errors = 0;
    string cur_req = "R1";
    bit    started = 1'b0;

    // Behavioural model state
    bit          m_conv, m_act, m_pend, m_armed, m_sq;
    int          m_tick, m_sbit;
    logic [17:0] m_word, m_hold;

    adc_serial_tx i_adc_serial_tx (
        .clk(clk), .rst_n(rst_n), .conv_go(conv_go), .res_strobe(res_strobe),
        .res_word(res_word), .clk_src_ext(clk_src_ext), .read_during(read_during),
        .rate_sel(rate_sel), .clk_pol_inv(clk_pol_inv), .sync_pol_inv(sync_pol_inv),
        .chip_sel_n(chip_sel_n), .read_n(read_n), .ext_clk(ext_clk),
        .conv_busy(conv_busy), .ser_clk(ser_clk), .frame_sync(frame_sync), .ser_data(ser_data)
    );

    always #(CLK_P/2) clk = ~clk;

    // Model update at each rising edge, from the inputs held since the last falling edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_conv = 0; m_act = 0; m_pend = 0; m_armed = 0; m_sq = 0;
            m_tick = 0; m_sbit = 0; m_word = '0; m_hold = '0;
        end else begin
            bit intl, selm, lv, busy_pre, go, fin, ld, st, ln, rs, step, last;
            int per;
            intl = !clk_src_ext;
            selm = !chip_sel_n && !read_n;
            lv = ext_clk ^ clk_pol_inv;
            per = 2 << rate_sel;
            busy_pre = m_conv || (intl && !read_during && m_act);
            go = conv_go && !busy_pre;
            fin = res_strobe && m_conv;
            ld = fin && !read_during;
            st = fin && read_during;
            ln = go && read_during && m_pend;
            rs = ld || ln;
            if (intl) begin
                step = m_act && ((m_tick % per) == per - 1);
                last = (m_tick / per) == 17;
            end else begin
                step = m_act && selm && !lv && m_sq && m_armed && !rs;
                last = (m_sbit == 17);
            end
            if (intl || !m_act || !selm || rs) m_armed = 0;
            else if (lv && !m_sq) m_armed = 1;
            else if (!lv && m_sq) m_armed = 0;
            m_sq = lv;
            if (go) m_conv = 1; else if (fin) m_conv = 0;
            if (ld) begin
                m_word = res_word; m_act = 1; m_tick = 0; m_sbit = 0;
            end else if (ln) begin
                m_word = m_hold; m_act = 1; m_tick = 0; m_sbit = 0; m_pend = 0;
            end else if (m_act && intl) begin
                if (step && last) begin m_act = 0; m_tick = 0; end
                else m_tick++;
            end else if (step) begin
                if (last) m_act = 0; else m_sbit++;
            end
            if (st) begin m_hold = res_word; m_pend = 1; m_act = 0; end
        end
    end

    task automatic cmp(input string nm, input logic got, input logic exp);
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b at %0t", cur_req, nm, got, exp, $time);
        end
    endtask

    // Compare all outputs a quarter period after each falling edge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (started) begin
            bit intl, e_busy, e_clk, e_sync, e_data;
            int per, idx;
            intl = !clk_src_ext;
            per = 2 << rate_sel;
            idx = intl ? (m_tick / per) : m_sbit;
            if (idx > 17) idx = 17;
            e_busy = m_conv || (intl && !read_during && m_act);
            e_clk = ((intl && m_act) ? ((m_tick % per) >= per/2) : 1'b0) ^ clk_pol_inv;
            e_sync = (intl && m_act) ^ sync_pol_inv;
            e_data = (m_act && (intl || (!chip_sel_n && !read_n))) ? m_word[17-idx] : 1'b0;
            vectors++;
            cmp("conv_busy", conv_busy, e_busy);
            cmp("ser_clk", ser_clk, e_clk);
            cmp("frame_sync", frame_sync, e_sync);
            cmp("ser_data", ser_data, e_data);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic convert(input logic [17:0] d, input int lat);
        @(negedge clk) conv_go = 1'b1;
        @(negedge clk) conv_go = 1'b0;
        repeat (lat) @(negedge clk);
        res_strobe = 1'b1; res_word = d;
        @(negedge clk) res_strobe = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && (m_act || m_conv); i++) @(negedge clk);
        idle(3);
    endtask

    task automatic ext_run(input int n, input int h, input logic rest);
        for (int i = 0; i < n; i++) begin
            ext_clk = !rest; idle(h);
            ext_clk = rest;  idle(h);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1: reset state, then a full transfer at the fastest rate
        cur_req = "R1"; idle(3);
        convert(18'h2A5C3, 6); wait_idle();
        // R2: each divide setting
        cur_req = "R2";
        rate_sel = 2'd1; convert(18'h1F0E1, 4); wait_idle();
        rate_sel = 2'd2; convert(18'h0ACE5, 4); wait_idle();
        rate_sel = 2'd3; convert(18'h3C3C3, 4); wait_idle();
        // R4: sync window with all ones and a single low bit set
        cur_req = "R4"; rate_sel = 2'd0;
        convert(18'h3FFFF, 5); wait_idle();
        convert(18'h00001, 5); wait_idle();
        // R5: both polarities inverted
        cur_req = "R5"; rate_sel = 2'd1; clk_pol_inv = 1'b1; sync_pol_inv = 1'b1;
        idle(3); convert(18'h15555, 3); wait_idle();
        clk_pol_inv = 1'b0; sync_pol_inv = 1'b0; rate_sel = 2'd0; idle(3);
        // R10: start while busy and a stray result are ignored
        cur_req = "R10";
        @(negedge clk) conv_go = 1'b1;
        @(negedge clk) conv_go = 1'b0;
        idle(2); conv_go = 1'b1; @(negedge clk) conv_go = 1'b0;
        idle(3); res_strobe = 1'b1; res_word = 18'h24924;
        @(negedge clk) res_strobe = 1'b0;
        idle(10); conv_go = 1'b1; @(negedge clk) conv_go = 1'b0;
        wait_idle();
        res_strobe = 1'b1; res_word = 18'h3F00F; @(negedge clk) res_strobe = 1'b0;
        idle(20);
        // R6: stored result sent during the next conversion
        cur_req = "R6"; read_during = 1'b1;
        convert(18'h12345, 5); idle(4);
        convert(18'h2BCDE, 50); idle(4);
        convert(18'h0F0F0, 50); wait_idle();
        read_during = 1'b0; idle(3);
        // R3: external clock, busy ends with the conversion
        cur_req = "R3"; clk_src_ext = 1'b1; ext_clk = 1'b0; idle(2);
        convert(18'h3A5A5, 6); idle(3);
        chip_sel_n = 1'b0; read_n = 1'b0; ext_run(18, 2, 1'b0);
        chip_sel_n = 1'b1; read_n = 1'b1; idle(4);
        // R7: clock ignored unless both selects are low
        cur_req = "R7";
        convert(18'h2D2D2, 4); ext_run(5, 1, 1'b0);
        chip_sel_n = 1'b1; read_n = 1'b0; ext_run(3, 2, 1'b0);
        chip_sel_n = 1'b0; read_n = 1'b1; ext_run(3, 2, 1'b0);
        read_n = 1'b0; ext_run(7, 1, 1'b0);
        read_n = 1'b1; ext_run(4, 1, 1'b0);
        read_n = 1'b0; ext_run(14, 3, 1'b0);
        chip_sel_n = 1'b1; read_n = 1'b1; idle(4);
        // R8: burst clock resting high, then an inverted continuous clock
        cur_req = "R8"; ext_clk = 1'b1; idle(2);
        convert(18'h1C71C, 4);
        chip_sel_n = 1'b0; read_n = 1'b0; ext_run(19, 2, 1'b1);
        chip_sel_n = 1'b1; read_n = 1'b1; idle(3);
        clk_pol_inv = 1'b1; ext_clk = 1'b1; idle(2);
        convert(18'h2F00D, 4);
        chip_sel_n = 1'b0; read_n = 1'b0; ext_run(20, 1, 1'b1);
        chip_sel_n = 1'b1; read_n = 1'b1; clk_pol_inv = 1'b0; ext_clk = 1'b0; idle(3);
        // R9: new result before the previous one is fully read
        cur_req = "R9";
        convert(18'h3FFC0, 4);
        chip_sel_n = 1'b0; read_n = 1'b0; ext_run(5, 2, 1'b0);
        convert(18'h0003F, 4); ext_run(18, 2, 1'b0);
        chip_sel_n = 1'b1; read_n = 1'b1; idle(4);
        clk_src_ext = 1'b0; idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule